// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous static memory with a built-in four-beat burst sequencer. A requester either presents a fresh address on every clock, giving one access per cycle with no bubbles, or loads a starting address once and then steps through three more locations with an advance strobe. The burst sequencer changes only the two low address bits. It visits them in either XOR (interleaved) order or wrap-around increment (linear) order. A mode input picks the order, and it is captured when the burst starts.

Reads leave the block in one of two ways, chosen at run time by an output-mode input. The flow-through path gives data in the cycle after the access, so a burst arrives 2-1-1-1. The registered path adds one output flop, so a burst arrives 3-1-1-1. Writes go lane by lane under per-byte enables, and a global-write input forces every lane. A sleep input freezes the memory: it blocks all accesses, ends any burst and parks the outputs while the stored data is kept. A valid-low flag stands in for a high-impedance data bus.

Top module: `sync_burst_sram`

## Requirements
- R1: After a cycle with `rst_n` low, `rvalid` is low and no burst is in progress.
- R2: A cycle with `sel` and `load` high accesses `addr` directly, and such cycles may follow each other on every clock with one access per cycle.
- R3: With `order_ilv` = 1 at load, beat b (0..3) of a burst uses low address bits equal to start[1:0] XOR b, and the upper bits never change.
- R4: With `order_ilv` = 0 at load, beat b uses low address bits (start[1:0] + b) mod 4, and the upper bits never change. The order captured at load holds for the whole burst.
- R5: With `out_reg` = 0, read data and `rvalid` appear in the cycle right after the clock edge that performs the access.
- R6: With `out_reg` = 1, read data and `rvalid` appear one cycle later than in R5.
- R7: On a write with `wr_all` = 0, byte lane i (bits [8i+7:8i]) is written only if `lane_en[i]` is 1. The other lanes keep their contents.
- R8: On a write with `wr_all` = 1, all lanes are written whatever `lane_en` holds. A write cycle never produces read data.
- R9: While `sleep` is high, reads and writes are ignored, `rvalid` is low and any burst ends. Stored data is unchanged after sleep.
- R10: A cycle with `sel` low performs no access and ends the burst. A later `adv` without a new load produces no access.
- R11: With `out_en` low, `rvalid` is low. Whenever `rvalid` is low, `rdata` is all zeros.
- R12: A cycle with `sel` = 1, `load` = 0 and `adv` = 0 performs no access and holds the beat count. The next `adv` continues with the following beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select; low deselects |
| load | input | 1 | Load `addr` as a new access and burst start |
| adv | input | 1 | Step the burst to the next beat |
| addr | input | ADDR_W | External word address |
| wr | input | 1 | 1 = write access, 0 = read access |
| wr_all | input | 1 | Global write: all lanes on a write |
| lane_en | input | LANES | Per-lane write enables |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_reg | input | 1 | Read path: 1 registered, 0 flow-through |
| out_en | input | 1 | Output enable |
| sleep | input | 1 | Low-power hold; blocks accesses |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid (low = outputs parked) |

## Verification
The bound checker watches on every cycle that sleep and a low output enable hold the outputs quiet, that parked data reads as zero, and that a loaded read shows up after exactly one or two cycles, depending on the output mode. It also checks that deselect, idle and write cycles produce no data on the flow-through path. Only the bench's scenarios can show which address each beat of a burst visits in either order, what happens to individual byte lanes, that sleep keeps stored contents, and how a suspended or deselected burst resumes or stops. For those, the bench sweeps every start address in both orders and both read modes against its own reference array.

// File: rtl/sbs_pkg.sv
// Package: shared helpers for the burst SRAM core.
// Assumes bursts are four beats long and touch only the two low address bits.
package sbs_pkg;

    // Low two address bits for a given beat in the chosen order.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
// Burst sequencer: decides whether this cycle accesses the array and at
// which address. A load takes the external address; an advance steps a
// two-bit beat count and rebuilds the low address bits in the order
// captured at load. Assumes ADDR_W >= 3.
module sbs_burst_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              load,
    input  logic              adv,
    input  logic              sleep,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_v,
    output logic [ADDR_W-1:0] acc_addr
);
    import sbs_pkg::*;

    logic              active_q;
    logic [1:0]        beat_q;
    logic [1:0]        nxt_beat;
    logic [ADDR_W-1:0] base_q;
    logic              ilv_q;
    logic              go_load;
    logic              go_adv;

    // Decode this cycle's access and its address.
    always_comb begin
        go_load  = sel & load & ~sleep;
        go_adv   = sel & ~load & adv & active_q & ~sleep;
        acc_v    = go_load | go_adv;
        nxt_beat = beat_q + 2'd1;
        acc_addr = go_load ? addr
                 : {base_q[ADDR_W-1:2], beat_low(base_q[1:0], nxt_beat, ilv_q)};
    end

    // Burst state: start, order, beat count and whether a burst is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= 2'd0;
            base_q   <= '0;
            ilv_q    <= 1'b1;
        end else if (go_load) begin
            active_q <= 1'b1;
            beat_q   <= 2'd0;
            base_q   <= addr;
            ilv_q    <= ilv;
        end else if (sleep || !sel) begin
            active_q <= 1'b0;
        end else if (go_adv) begin
            beat_q   <= nxt_beat;
        end
    end
endmodule

// File: rtl/sbs_array.sv
// Storage: one register array per byte lane, written per lane enable and
// read combinationally at a separate read address. Contents are not reset.
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_v,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Write this lane when the access is a write and the lane is enabled.
        always_ff @(posedge clk) begin
            if (wr_v && wr_lanes[g])
                lane_mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/sbs_rdpath.sv
// Read return path: holds the read address for one cycle (flow-through
// view) and adds an optional output register (registered view). The mode
// select is live, so it can change between accesses. Sleep and output
// enable park the outputs; parked data reads as zero.
module sbs_rdpath #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              sleep,
    input  logic              out_reg,
    input  logic              out_en,
    input  logic [DATA_W-1:0] mem_rd,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic              rd_v_q;
    logic [ADDR_W-1:0] rd_a_q;
    logic              pv_q;
    logic [DATA_W-1:0] pd_q;
    logic              sel_v;
    logic [DATA_W-1:0] sel_d;

    // Address stage and output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q <= 1'b0;
            rd_a_q <= '0;
            pv_q   <= 1'b0;
            pd_q   <= '0;
        end else begin
            rd_v_q <= acc_rd;
            if (acc_rd)
                rd_a_q <= acc_addr;
            pv_q   <= rd_v_q & ~sleep;
            pd_q   <= mem_rd;
        end
    end

    assign rd_addr = rd_a_q;

    // Pick the path, then gate by sleep and output enable.
    always_comb begin
        sel_v  = out_reg ? pv_q : rd_v_q;
        sel_d  = out_reg ? pd_q : mem_rd;
        rvalid = sel_v & out_en & ~sleep;
        rdata  = rvalid ? sel_d : '0;
    end
endmodule

// File: rtl/sync_burst_sram.sv
// Top: single-port synchronous burst SRAM. The sequencer picks the access
// address, the array stores lanes, and the read path returns data in
// flow-through or registered mode. A global write forces all lanes.
module sync_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    load,
    input  logic                    adv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr,
    input  logic                    wr_all,
    input  logic [LANES-1:0]        lane_en,
    input  logic                    order_ilv,
    input  logic                    out_reg,
    input  logic                    out_en,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    logic              acc_v;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_rd;
    logic              acc_rd;
    logic              acc_wr;
    logic [LANES-1:0]  lanes;

    // Split the access into read or write and resolve the lane mask.
    always_comb begin
        acc_rd = acc_v & ~wr;
        acc_wr = acc_v & wr;
        lanes  = wr_all ? {LANES{1'b1}} : lane_en;
    end

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .sel(sel), .load(load), .adv(adv),
        .sleep(sleep), .ilv(order_ilv), .addr(addr),
        .acc_v(acc_v), .acc_addr(acc_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .wr_v(acc_wr), .wr_addr(acc_addr), .wr_lanes(lanes),
        .wdata(wdata), .rd_addr(rd_addr), .rd_data(mem_rd)
    );

    sbs_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_addr(acc_addr),
        .sleep(sleep), .out_reg(out_reg), .out_en(out_en), .mem_rd(mem_rd),
        .rd_addr(rd_addr), .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: rtl/sbs_checker.sv
// Checker: cycle-level properties of the burst SRAM ports.
module sbs_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              load,
    input logic              adv,
    input logic              wr,
    input logic              sleep,
    input logic              out_reg,
    input logic              out_en,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata
);
    // R1: outputs parked right after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !rvalid);

    // R9: sleep keeps outputs parked.
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rvalid);

    // R11: output enable gates valid; parked data is zero.
    a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !rvalid);
    a_r11_zero_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);

    // R5: flow-through read returns in the next cycle.
    a_r5_ft_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && load && !wr && !sleep) |=> (out_reg || !out_en || sleep || rvalid));

    // R6: registered read returns one cycle later.
    a_r6_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && load && !wr && !sleep) ##1 !sleep |=> (!out_reg || !out_en || sleep || rvalid));

    // R10 and R12: deselect, sleep or idle cycles make no flow-through data.
    a_r10_no_access_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || sleep || (!load && !adv)) |=> (out_reg || !rvalid));

    // R8: writes never produce read data.
    a_r8_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !sleep) |=> (out_reg || !rvalid));
endmodule

bind sync_burst_sram sbs_checker #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .load(load), .adv(adv), .wr(wr),
    .sleep(sleep), .out_reg(out_reg), .out_en(out_en),
    .rvalid(rvalid), .rdata(rdata)
);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 8;
    localparam int DW = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 0, load = 0, adv = 0, wr = 0, wr_all = 0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_en = '0;
    logic          order_ilv = 1, out_reg = 0, out_en = 1, sleep = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .load(load), .adv(adv),
        .addr(addr), .wr(wr), .wr_all(wr_all), .lane_en(lane_en),
        .order_ilv(order_ilv), .out_reg(out_reg), .out_en(out_en),
        .sleep(sleep), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        sel = 0; load = 0; adv = 0; wr = 0; wr_all = 0; lane_en = '0;
    endtask

    // One write cycle loading addr a; reference updated per lane rules.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [LN-1:0] le, input logic all);
        @(negedge clk);
        sel = 1; load = 1; adv = 0; wr = 1; addr = a; wdata = d;
        lane_en = le; wr_all = all;
        for (int l = 0; l < LN; l++)
            if (all || le[l]) ref_mem[a][l*LW +: LW] = d[l*LW +: LW];
    endtask

    task automatic read_one(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        idle(); out_reg = 0; sel = 1; load = 1; addr = a;
        @(negedge clk);
        check(req, {31'd0, rvalid}, 32'd1);
        check(req, rdata, ref_mem[a]);
        idle();
    endtask

    // Back-to-back single reads of every address.
    task automatic read_all(input logic pipe);
        int lat;
        lat = pipe ? 2 : 1;
        for (int i = 0; i < DEPTH + lat; i++) begin
            @(negedge clk);
            if (i >= lat) begin
                check(pipe ? "R2 R6 valid" : "R2 R5 valid", {31'd0, rvalid}, 32'd1);
                check(pipe ? "R2 R6 data" : "R2 R5 data", rdata, ref_mem[i-lat]);
            end
            idle(); out_reg = pipe;
            if (i < DEPTH) begin sel = 1; load = 1; addr = i[AW-1:0]; end
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int b, input logic ilv);
        logic [1:0] bb;
        bb = b[1:0];
        return {s[AW-1:2], ilv ? (s[1:0] ^ bb) : (s[1:0] + bb)};
    endfunction

    task automatic burst_read(input logic [AW-1:0] s, input logic ilv, input logic pipe);
        int lat;
        lat = pipe ? 2 : 1;
        for (int i = 0; i < 4 + lat; i++) begin
            @(negedge clk);
            if (i >= lat) begin
                check(ilv ? "R3 valid" : "R4 valid", {31'd0, rvalid}, 32'd1);
                check(ilv ? (pipe ? "R3 R6 data" : "R3 R5 data")
                          : (pipe ? "R4 R6 data" : "R4 R5 data"),
                      rdata, ref_mem[beat_addr(s, i - lat, ilv)]);
            end
            idle(); out_reg = pipe;
            if (i == 0) begin sel = 1; load = 1; addr = s; order_ilv = ilv; end
            else if (i < 4) begin sel = 1; adv = 1; order_ilv = ~ilv; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset rvalid", {31'd0, rvalid}, 32'd0);
        check("R11 reset rdata", rdata, '0);

        // Fill with global writes, back to back.
        for (int a = 0; a < DEPTH; a++)
            do_write(a[AW-1:0], DW'(a * 16'h0137 + 16'h005a), '0, 1'b1);
        @(negedge clk); idle();
        check("R8 no data after writes", {31'd0, rvalid}, 32'd0);

        read_all(1'b0);
        read_all(1'b1);

        // Every start address, both orders, both read modes.
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < DEPTH; s++)
                burst_read(s[AW-1:0], m[0], m[1]);

        // Byte lanes.
        do_write(6'd5, 16'hABCD, 2'b01, 1'b0);
        do_write(6'd6, 16'h1234, 2'b10, 1'b0);
        do_write(6'd7, 16'h9E8F, 2'b00, 1'b1);
        do_write(6'd8, 16'h7777, 2'b00, 1'b0);
        @(negedge clk); idle();
        read_one(6'd5, "R7 low lane");
        read_one(6'd6, "R7 high lane");
        read_one(6'd7, "R8 global write");
        read_one(6'd8, "R7 no lanes");

        // Burst write in linear order from 41, then read back.
        @(negedge clk);
        idle(); sel = 1; load = 1; wr = 1; wr_all = 1; addr = 6'd41; order_ilv = 0; wdata = 16'hC001;
        ref_mem[41] = 16'hC001;
        for (int b = 1; b < 4; b++) begin
            @(negedge clk);
            idle(); sel = 1; adv = 1; wr = 1; wr_all = 1; wdata = DW'(16'hC001 + b);
            ref_mem[beat_addr(6'd41, b, 1'b0)] = DW'(16'hC001 + b);
        end
        @(negedge clk); idle();
        burst_read(6'd41, 1'b0, 1'b0);

        // Sleep: writes and reads ignored, outputs parked, data kept.
        @(negedge clk);
        idle(); sleep = 1; sel = 1; load = 1; wr = 1; wr_all = 1; addr = 6'd9; wdata = 16'hFFFF;
        @(negedge clk);
        check("R9 sleep rvalid", {31'd0, rvalid}, 32'd0);
        idle(); sel = 1; load = 1; addr = 6'd9;
        @(negedge clk);
        check("R9 sleep read parked", {31'd0, rvalid}, 32'd0);
        idle(); sleep = 0;
        read_one(6'd9, "R9 data kept");

        // Sleep ends a burst.
        @(negedge clk); idle(); out_reg = 0; sel = 1; load = 1; addr = 6'd12; order_ilv = 1;
        @(negedge clk); check("R9 pre-sleep load", rdata, ref_mem[12]);
        idle(); sleep = 1; sel = 1;
        @(negedge clk); idle(); sleep = 0; sel = 1; adv = 1;
        @(negedge clk);
        check("R9 burst ended", {31'd0, rvalid}, 32'd0);
        idle();

        // Deselect ends a burst, flow-through.
        @(negedge clk); idle(); out_reg = 0; sel = 1; load = 1; addr = 6'd20; order_ilv = 1;
        @(negedge clk); check("R10 first beat", rdata, ref_mem[20]);
        idle();
        @(negedge clk); check("R10 deselect quiet", {31'd0, rvalid}, 32'd0);
        idle(); sel = 1; adv = 1;
        @(negedge clk); check("R10 adv after deselect", {31'd0, rvalid}, 32'd0);
        idle();

        // Deselect with registered output: data then quiet.
        @(negedge clk); idle(); out_reg = 1; sel = 1; load = 1; addr = 6'd22;
        @(negedge clk); idle();
        @(negedge clk); check("R10 R6 data before quiet", rdata, ref_mem[22]);
        @(negedge clk); check("R10 R6 quiet", {31'd0, rvalid}, 32'd0);

        // Suspend holds the beat.
        @(negedge clk); idle(); out_reg = 0; sel = 1; load = 1; addr = 6'd33; order_ilv = 1;
        @(negedge clk); check("R12 beat0", rdata, ref_mem[33]);
        idle(); sel = 1;
        @(negedge clk); check("R12 suspend quiet", {31'd0, rvalid}, 32'd0);
        idle(); sel = 1; adv = 1;
        @(negedge clk); check("R12 resume beat1", rdata, ref_mem[32]);
        idle();

        // Output enable low.
        @(negedge clk); idle(); out_en = 0; sel = 1; load = 1; addr = 6'd3;
        @(negedge clk);
        check("R11 oe rvalid", {31'd0, rvalid}, 32'd0);
        check("R11 oe rdata", rdata, '0);
        idle(); out_en = 1;

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule